// File: doc/BRIEF.md
# Instruction Dispatch Group Former

This block sits after instruction pre-decode. It packs a stream of tagged instructions into dispatch groups of six slots. Slots 1 to 4 hold non-branch instructions and slots 5 and 6 hold branches. Each instruction carries a 4-bit class code. The code decides which slots the instruction may take, and whether it can join the group being built or must first force that group out. A group is kept in a builder register until it closes. It then moves to an output register and is presented with a valid strobe, a slot-occupancy mask and one tag per slot.

Both sides use valid/ready handshakes. When the output register holds an unaccepted group and the builder must close, the input is stalled. Instructions keep their arrival order, both within a group and across groups. A builder that is still open gets flushed as soon as the input goes idle for one cycle, provided the output register can take it.

Top module: `dispatch_group_former`

## Requirements
- R1: After reset no group is valid and `inReady` is high.
- R2: Class codes are 0 simple, 1 slot-1-only, 2 cracked pair, 3 four-slot, 4 permute and 5 branch. Codes 6 to 15 behave exactly like simple. `grpMask` bit i means slot i+1 is occupied. The tag of slot i+1 is `grpTags[i*TAG_W +: TAG_W]`.
- R3: A simple instruction takes the lowest free slot among slots 1 to 4. The occupied non-branch slots of any group always form a prefix starting at slot 1.
- R4: Branches take slot 5 and then slot 6. One branch leaves the group open. A second branch closes the group right after it is placed, so a group never has slot 6 without slot 5.
- R5: A slot-1-only instruction joins only while slot 1 is free. Otherwise it starts a new group.
- R6: A cracked-pair instruction takes slots 1 and 2, both carrying its tag. It joins only while slots 1 to 4 are all free.
- R7: A four-slot instruction takes slots 1 to 4, all carrying its tag. It joins only while slots 1 to 4 are all free.
- R8: A permute instruction takes slot 1 or slot 2, whichever is the lower free one. If both are used it starts a new group.
- R9: A group is emitted when the next instruction cannot be placed, or when the input is idle for a cycle. An empty group is never emitted. Instructions are never reordered or lost. While no group is waiting at the output, `inReady` is high.
- R10: While `grpValid` is high and `grpReady` is low, `grpValid`, `grpMask` and `grpTags` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input instruction valid |
| inReady | output | 1 | Input instruction accepted this cycle when high with inValid |
| inClass | input | 4 | Instruction class code |
| inTag | input | TAG_W | Instruction tag |
| grpValid | output | 1 | Group on the output is valid |
| grpReady | input | 1 | Downstream accepts the group |
| grpMask | output | 6 | Occupied slots, bit i is slot i+1 |
| grpTags | output | 6*TAG_W | Per-slot tags |

## Verification
The assertions watch every cycle for these properties: the output stays stable under backpressure, no empty group is emitted, slot 6 never appears without slot 5, the non-branch slots form a prefix from slot 1, and input is never stalled while the output is free. Other behaviour depends on the order of the stream and can only be shown by the bench scenarios. This covers where each class lands, which instruction forces a new group, closing after a second branch, flushing on an idle cycle, and the exact tag in every slot. The bench sweeps every three-instruction class sequence and then a set of longer pseudo-random sequences. It applies random backpressure throughout and compares each group against an independent packing model.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
  localparam int CLS_W    = 4;
  localparam int NB_SLOTS = 4;
  localparam int BR_SLOTS = 2;
  localparam int SLOTS    = NB_SLOTS + BR_SLOTS;

  localparam logic [CLS_W-1:0] CLS_SIMPLE = 4'd0;
  localparam logic [CLS_W-1:0] CLS_SLOT1  = 4'd1;
  localparam logic [CLS_W-1:0] CLS_PAIR   = 4'd2;
  localparam logic [CLS_W-1:0] CLS_QUAD   = 4'd3;
  localparam logic [CLS_W-1:0] CLS_PERM   = 4'd4;
  localparam logic [CLS_W-1:0] CLS_BRANCH = 4'd5;

  typedef struct packed {
    logic             emit;       // move builder to output register
    logic             place;      // write incoming instruction into builder
    logic [SLOTS-1:0] placeMask;  // slots the incoming instruction takes
  } dgfStrobe_t;
endpackage

// File: rtl/dgf_ctrl.sv
module dgf_ctrl
  import dgf_pkg::*;
(
  input  logic             inValid,
  input  logic [CLS_W-1:0] inClass,
  input  logic             grpReady,
  input  logic             oValid,
  input  logic [SLOTS-1:0] bMask,
  output logic             inReady,
  output dgfStrobe_t       strobe
);
  // Returns {fits, slotMask} for class c against occupancy m.
  function automatic logic [SLOTS:0] placeFor(input logic [CLS_W-1:0] c,
                                              input logic [SLOTS-1:0] m);
    logic ok;
    logic [SLOTS-1:0] p;
    ok = 1'b0;
    p  = '0;
    if (!m[SLOTS-1]) begin
      case (c)
        CLS_SLOT1: if (!m[0]) begin ok = 1'b1; p[0] = 1'b1; end
        CLS_PAIR:  if (m[NB_SLOTS-1:0] == '0) begin ok = 1'b1; p[1:0] = 2'b11; end
        CLS_QUAD:  if (m[NB_SLOTS-1:0] == '0) begin ok = 1'b1; p[NB_SLOTS-1:0] = '1; end
        CLS_PERM: begin
          if (!m[0]) begin ok = 1'b1; p[0] = 1'b1; end
          else if (!m[1]) begin ok = 1'b1; p[1] = 1'b1; end
        end
        CLS_BRANCH: begin
          ok = 1'b1;
          if (!m[NB_SLOTS]) p[NB_SLOTS] = 1'b1;
          else p[NB_SLOTS+1] = 1'b1;
        end
        default: begin
          for (int i = 0; i < NB_SLOTS; i++) begin
            if (!ok && !m[i]) begin ok = 1'b1; p[i] = 1'b1; end
          end
        end
      endcase
    end
    return {ok, p};
  endfunction

  logic [SLOTS:0] curFit;
  logic [SLOTS:0] freshFit;
  logic busy, outFree, mustClose;

  always_comb begin
    curFit    = placeFor(inClass, bMask);
    freshFit  = placeFor(inClass, '0);
    busy      = |bMask;
    outFree   = !oValid || grpReady;
    mustClose = busy && (!inValid || !curFit[SLOTS]);
    inReady   = curFit[SLOTS] || outFree;
    strobe.emit      = mustClose && outFree;
    strobe.place     = inValid && inReady;
    strobe.placeMask = strobe.emit ? freshFit[SLOTS-1:0] : curFit[SLOTS-1:0];
  end
endmodule

// File: rtl/dgf_data.sv
module dgf_data
  import dgf_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dgfStrobe_t             strobe,
  input  logic [TAG_W-1:0]       inTag,
  input  logic                   grpReady,
  output logic [SLOTS-1:0]       bMask,
  output logic                   oValid,
  output logic [SLOTS-1:0]       oMask,
  output logic [SLOTS*TAG_W-1:0] oTags
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oValid <= 1'b0;
      oMask  <= '0;
      bMask  <= '0;
    end else begin
      if (strobe.emit) begin
        oValid <= 1'b1;
        oMask  <= bMask;
      end else if (grpReady) begin
        oValid <= 1'b0;
      end
      if (strobe.emit)
        bMask <= strobe.place ? strobe.placeMask : '0;
      else if (strobe.place)
        bMask <= bMask | strobe.placeMask;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : gSlot
    logic [TAG_W-1:0] bTag;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bTag                     <= '0;
        oTags[s*TAG_W +: TAG_W]  <= '0;
      end else begin
        if (strobe.place && strobe.placeMask[s]) bTag <= inTag;
        if (strobe.emit) oTags[s*TAG_W +: TAG_W] <= bTag;
      end
    end
  end
endmodule

// File: rtl/dispatch_group_former.sv
module dispatch_group_former
  import dgf_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [CLS_W-1:0]       inClass,
  input  logic [TAG_W-1:0]       inTag,
  output logic                   grpValid,
  input  logic                   grpReady,
  output logic [SLOTS-1:0]       grpMask,
  output logic [SLOTS*TAG_W-1:0] grpTags
);
  dgfStrobe_t       strobe;
  logic [SLOTS-1:0] bMask;

  dgf_ctrl uCtrl (
    .inValid (inValid),
    .inClass (inClass),
    .grpReady(grpReady),
    .oValid  (grpValid),
    .bMask   (bMask),
    .inReady (inReady),
    .strobe  (strobe)
  );

  dgf_data #(.TAG_W(TAG_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inTag   (inTag),
    .grpReady(grpReady),
    .bMask   (bMask),
    .oValid  (grpValid),
    .oMask   (grpMask),
    .oTags   (grpTags)
  );
endmodule

// File: rtl/dgf_checker.sv
module dgf_checker
  import dgf_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   inValid,
  input logic                   inReady,
  input logic [CLS_W-1:0]       inClass,
  input logic [TAG_W-1:0]       inTag,
  input logic                   grpValid,
  input logic                   grpReady,
  input logic [SLOTS-1:0]       grpMask,
  input logic [SLOTS*TAG_W-1:0] grpTags
);
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    grpValid && !grpReady |=> grpValid && $stable(grpMask) && $stable(grpTags));

  a_r9_no_empty_group: assert property (@(posedge clk) disable iff (!rstN)
    grpValid |-> grpMask != '0);

  a_r9_ready_when_free: assert property (@(posedge clk) disable iff (!rstN)
    !grpValid |-> inReady);

  a_r4_branch_order: assert property (@(posedge clk) disable iff (!rstN)
    grpValid && grpMask[SLOTS-1] |-> grpMask[NB_SLOTS]);

  a_r3_prefix_fill: assert property (@(posedge clk) disable iff (!rstN)
    grpValid |-> (grpMask[NB_SLOTS-1:0] == 4'b0000 || grpMask[NB_SLOTS-1:0] == 4'b0001 ||
                  grpMask[NB_SLOTS-1:0] == 4'b0011 || grpMask[NB_SLOTS-1:0] == 4'b0111 ||
                  grpMask[NB_SLOTS-1:0] == 4'b1111));
endmodule

bind dispatch_group_former dgf_checker #(.TAG_W(TAG_W)) uChk (.*);

// File: tb/tb_dispatch_group_former.sv
module tb_dispatch_group_former;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;

  typedef struct packed {
    logic [5:0]    mask;
    logic [6*TW-1:0] tags;
    logic [3:0]    rank;
  } grp_t;

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, grpReady = 1'b0;
  logic [3:0] inClass = '0;
  logic [TW-1:0] inTag = '0;
  logic inReady, grpValid;
  logic [5:0] grpMask;
  logic [6*TW-1:0] grpTags;

  dispatch_group_former #(.TAG_W(TW)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inClass(inClass), .inTag(inTag), .grpValid(grpValid),
    .grpReady(grpReady), .grpMask(grpMask), .grpTags(grpTags));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic forceReady = 1'b0;
  logic [31:0] rngR = 32'h1357_9bdf, rngD = 32'h2468_ace1;
  logic [TW-1:0] tagCnt = '0;
  grp_t expQ[$];

  // packing model state: non-branch slots used, branches used
  int mNb = 0, mBr = 0;
  logic [5:0] mMask = '0;
  logic [6*TW-1:0] mTags = '0;
  logic [3:0] mRank = '0;

  function automatic string rankName(input logic [3:0] r);
    case (r)
      4'd7: return "R7";  4'd6: return "R6";  4'd5: return "R8";
      4'd4: return "R5";  4'd3: return "R4";  4'd2: return "R2";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
    return t;
  endfunction

  task automatic flushModel();
    grp_t g;
    if (mMask != 0) begin
      g.mask = mMask; g.tags = mTags; g.rank = mRank;
      expQ.push_back(g);
    end
    mNb = 0; mBr = 0; mMask = '0; mTags = '0; mRank = '0;
  endtask

  task automatic putSlot(input int s, input logic [TW-1:0] t);
    mMask[s] = 1'b1;
    mTags[s*TW +: TW] = t;
  endtask

  task automatic modelPlace(input logic [3:0] code, input logic [TW-1:0] t);
    int kind;
    bit ok;
    logic [3:0] r;
    kind = (code <= 4'd5) ? int'(code) : 0;
    case (kind)
      1: ok = (mNb == 0);
      2, 3: ok = (mNb == 0);
      4: ok = (mNb < 2);
      5: ok = (mBr < 2);
      default: ok = (mNb < 4);
    endcase
    if (mBr == 2) ok = 0;
    if (!ok) flushModel();
    case (kind)
      2: begin putSlot(0, t); putSlot(1, t); mNb = 2; r = 4'd6; end
      3: begin for (int k = 0; k < 4; k++) putSlot(k, t); mNb = 4; r = 4'd7; end
      5: begin putSlot(4 + mBr, t); mBr = mBr + 1; r = 4'd3; end
      default: begin
        putSlot(mNb, t); mNb = mNb + 1;
        r = (kind == 1) ? 4'd4 : (kind == 4) ? 4'd5 : (code > 4'd5) ? 4'd2 : 4'd1;
      end
    endcase
    if (r > mRank) mRank = r;
    if (mBr == 2) flushModel();
  endtask

  task automatic sendOne(input logic [3:0] code);
    @(negedge clk);
    inValid = 1'b1; inClass = code; inTag = tagCnt;
    modelPlace(code, tagCnt);
    tagCnt = tagCnt + 1'b1;
    #3;
    while (!inReady) begin @(negedge clk); #3; end
    @(posedge clk);
  endtask

  task automatic idleGap();
    @(negedge clk);
    inValid = 1'b0; forceReady = 1'b1;
    flushModel();
    @(negedge clk);
    @(negedge clk);
    forceReady = 1'b0;
  endtask

  // output monitor and backpressure driver
  logic stallPrev = 1'b0;
  logic [5:0] hMask;
  logic [6*TW-1:0] hTags;
  always begin
    @(negedge clk);
    #1;
    rngR = xs(rngR);
    grpReady = forceReady || (rngR[1:0] != 2'b00);
    #1;
    if (rstN) begin
      if (stallPrev) begin
        checks++;
        if (!grpValid || grpMask != hMask || grpTags != hTags) begin
          fails++;
          $display("FAIL R10 held group changed: valid=%0b mask=%b tags=%h expected valid=1 mask=%b tags=%h",
                   grpValid, grpMask, grpTags, hMask, hTags);
        end
      end
      if (grpValid && grpReady) begin
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R9 unexpected group mask=%b expected no group", grpMask);
        end else begin
          grp_t e;
          bit bad;
          e = expQ.pop_front();
          bad = (grpMask != e.mask);
          for (int s = 0; s < 6; s++)
            if (e.mask[s] && grpTags[s*TW +: TW] != e.tags[s*TW +: TW]) bad = 1;
          if (bad) begin
            fails++;
            $display("FAIL %s group mismatch: mask=%b tags=%h expected mask=%b tags=%h",
                     rankName(e.rank), grpMask, grpTags, e.mask, e.tags);
          end
        end
      end
      stallPrev = grpValid && !grpReady;
      hMask = grpMask; hTags = grpTags;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: run hung after %0d cycles, expected completion", 190000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #3;
    checks++;
    if (grpValid !== 1'b0 || inReady !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset state: grpValid=%b inReady=%b expected 0 1", grpValid, inReady);
    end

    // exhaustive three-instruction sweep; index 6 selects an undefined code (R2)
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++)
        for (int c = 0; c < 7; c++) begin
          int u;
          u = 6 + ((a * 7 + b * 3 + c) % 10);
          sendOne(a == 6 ? 4'(u) : 4'(a));
          sendOne(b == 6 ? 4'(u) : 4'(b));
          sendOne(c == 6 ? 4'(u) : 4'(c));
          idleGap();
        end

    // longer pseudo-random streams
    for (int n = 0; n < 300; n++) begin
      int len;
      rngD = xs(rngD);
      len = 1 + int'(rngD[2:0]);
      for (int k = 0; k < len; k++) begin
        rngD = xs(rngD);
        sendOne(rngD[7:4]);
      end
      idleGap();
    end

    forceReady = 1'b1;
    repeat (6) @(negedge clk);
    #3;
    checks++;
    if (expQ.size() != 0 || grpValid) begin
      fails++;
      $display("FAIL R9 groups left after drain: pending=%0d valid=%b expected 0 0",
               expQ.size(), grpValid);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule